// File: doc/BRIEF.md
# Legacy I/O Configuration Port Controller

This block is the configuration front end of a legacy I/O controller. It sits on a simple byte-wide host I/O bus and answers at two adjacent addresses: an index port and a data port. A strap input chooses which address pair is used. While the block is locked, the ports ignore all traffic except one thing: the host must write a key byte to the index port twice in a row to open configuration access. A different key byte closes access again.

When access is open, a write to the index port picks a register number. A read or write on the data port then reaches that register. Some registers are global. Others are banked: a logical-device number register chooses which of several logical devices the enable and I/O base registers refer to, and each device keeps its own copy. The enable bit and 16-bit base of every device are driven out continuously to the device logic. A global clock-select bit is also driven out. Data-port reads return the live register contents, so firmware can change single bits with read-modify-write.

Top module: `sio_cfg_port`

## Requirements
- R1: Configuration access opens only after two consecutive index-port writes of 0x87. Any other write to the index or data port between them restarts the key search.
- R2: While access is open, writing 0xAA to the index port locks the block again. That write does not change the selected register number.
- R3: With strap_alt_i low the index/data ports are at 0x4E/0x4F; with it high they are at 0x2E/0x2F. Accesses to any other address have no effect and read 0xFF.
- R4: While access is open, any index-port write other than 0xAA sets the selected register number. Index-port reads return that number, and data-port accesses go to that register.
- R5: Data-port reads return the current contents of the selected register: 0x07 gives the full logical-device byte, 0x24 gives the full global byte, 0x30 gives the selected device's enable in bit 0 with zeros above it, 0x60 gives the high base byte and 0x61 the low base byte.
- R6: clk48_sel_o follows bit 6 of register 0x24. It changes in the cycle after the data-port write.
- R7: Register 0x07 selects a logical device 0..NDEV-1. Registers 0x30 bit 0, 0x60 and 0x61 reach only that device's copy. Device i's copies drive dev_en_o[i] and dev_base_o[16*i +: 16].
- R8: While locked, data-port writes change nothing. rdata_o reads 0xFF for locked reads and whenever no configuration read is in progress.
- R9: Writes to undefined register numbers are discarded, and reads of them return 0x00. The same holds for per-device registers while register 0x07 holds a number of NDEV or more.
- R10: Reset clears every register and the selected register number, locks the block and restarts the key search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_alt_i | input | 1 | Selects the alternate port pair |
| addr_i | input | ADDR_W | Host I/O address |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational while rd_i is high |
| dev_en_o | output | NDEV | Enable bit of each logical device |
| dev_base_o | output | 16*NDEV | I/O base of each logical device, device i at bits 16*i+15:16*i |
| clk48_sel_o | output | 1 | Clock-select bit, register 0x24 bit 6 |

## Verification
The bench uses the default NDEV of 4 with a 16-bit address. Device numbers 0 to 5 are written to register 0x07, so both the real banks and the out-of-range numbers 4 and 5 are exercised, where per-device accesses must read zero and be discarded. Random traffic runs under both strap settings and mixes key bytes, including broken and repeated key sequences, with register traffic. A reset applied in the middle of a run checks that the block recovers.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] REG_LDN   = 8'h07;
  localparam logic [7:0] REG_GCR   = 8'h24;
  localparam logic [7:0] REG_EN    = 8'h30;
  localparam logic [7:0] REG_BHI   = 8'h60;
  localparam logic [7:0] REG_BLO   = 8'h61;
  localparam int unsigned CLK48_BIT = 6;

  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_st_e;
endpackage

// File: rtl/sio_port_dec.sv
module sio_port_dec #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PRI_BASE = 'h4E,
  parameter logic [ADDR_W-1:0] ALT_BASE = 'h2E
) (
  input  logic              strap_alt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              idx_rd_o,
  output logic              dat_rd_o
);
  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              hit_idx, hit_dat;

  assign idx_addr = strap_alt_i ? ALT_BASE : PRI_BASE;
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign hit_idx  = (addr_i == idx_addr);
  assign hit_dat  = (addr_i == dat_addr);

  assign idx_wr_o = wr_i & hit_idx;
  assign dat_wr_o = wr_i & hit_dat;
  assign idx_rd_o = rd_i & hit_idx;
  assign dat_rd_o = rd_i & hit_dat;
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic       dat_wr_i,
  input  logic [7:0] wdata_i,
  output logic       cfg_open_o,
  output logic       sel_wr_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      KS_LOCKED: if (idx_wr_i && wdata_i == KEY_ENTER) st_d = KS_HALF;
      KS_HALF: begin
        if (idx_wr_i)      st_d = (wdata_i == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        else if (dat_wr_i) st_d = KS_LOCKED;
      end
      KS_OPEN:   if (idx_wr_i && wdata_i == KEY_EXIT) st_d = KS_LOCKED;
      default:   st_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;
  end

  assign cfg_open_o = (st_q == KS_OPEN);
  assign sel_wr_o   = cfg_open_o & idx_wr_i & (wdata_i != KEY_EXIT);

  // R1: the only way into config is a second entry key from the half state
  p_unlock_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_OPEN && $past(st_q) != KS_OPEN) |->
      ($past(st_q) == KS_HALF && $past(idx_wr_i) && $past(wdata_i) == KEY_ENTER));

  p_break_seq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_HALF && dat_wr_i) |=> (st_q == KS_LOCKED));

  p_exit_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_OPEN && idx_wr_i && wdata_i == KEY_EXIT) |=> (st_q == KS_LOCKED));
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NDEV = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_open_i,
  input  logic               sel_wr_i,
  input  logic               dat_wr_i,
  input  logic               idx_rd_i,
  input  logic               dat_rd_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [NDEV-1:0]    dev_en_o,
  output logic [16*NDEV-1:0] dev_base_o,
  output logic               clk48_sel_o
);
  localparam int unsigned DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [7:0]  NDEV_B = 8'(NDEV);

  logic [7:0]       idx_q, ldn_q, gcr_q;
  logic             en_q   [NDEV];
  logic [15:0]      base_q [NDEV];
  logic [DEV_W-1:0] dev_sel;
  logic             ldn_hit, cfg_wr;
  logic [7:0]       reg_val;

  assign dev_sel = ldn_q[DEV_W-1:0];
  assign ldn_hit = (ldn_q < NDEV_B);
  assign cfg_wr  = cfg_open_i & dat_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
      gcr_q <= '0;
    end else begin
      if (sel_wr_i) idx_q <= wdata_i;
      if (cfg_wr && idx_q == REG_LDN) ldn_q <= wdata_i;
      if (cfg_wr && idx_q == REG_GCR) gcr_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic dev_wr;
    assign dev_wr = cfg_wr & ldn_hit & (dev_sel == DEV_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        base_q[i] <= '0;
      end else if (dev_wr) begin
        if (idx_q == REG_EN)  en_q[i]          <= wdata_i[0];
        if (idx_q == REG_BHI) base_q[i][15:8]  <= wdata_i;
        if (idx_q == REG_BLO) base_q[i][7:0]   <= wdata_i;
      end
    end

    assign dev_en_o[i]            = en_q[i];
    assign dev_base_o[16*i +: 16] = base_q[i];

    // R7: a device that is not selected keeps its registers
    p_bank_isolate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dat_wr_i && ldn_q != 8'(i)) |=> ($stable(dev_en_o[i]) && $stable(dev_base_o[16*i +: 16])));
  end

  always_comb begin
    reg_val = 8'h00;
    unique case (idx_q)
      REG_LDN: reg_val = ldn_q;
      REG_GCR: reg_val = gcr_q;
      REG_EN:  if (ldn_hit) reg_val = {7'b0, en_q[dev_sel]};
      REG_BHI: if (ldn_hit) reg_val = base_q[dev_sel][15:8];
      REG_BLO: if (ldn_hit) reg_val = base_q[dev_sel][7:0];
      default: reg_val = 8'h00;
    endcase
  end

  always_comb begin
    rdata_o = 8'hFF;
    if (cfg_open_i && idx_rd_i)      rdata_o = idx_q;
    else if (cfg_open_i && dat_rd_i) rdata_o = reg_val;
  end

  assign clk48_sel_o = gcr_q[CLK48_BIT];

  // R6
  p_clk48_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr && idx_q == REG_GCR) |=> (clk48_sel_o == $past(wdata_i[CLK48_BIT])));

  // R8: locked data writes leave all register state alone
  p_locked_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_open_i && dat_wr_i) |=>
      ($stable(gcr_q) && $stable(ldn_q) && $stable(dev_en_o) && $stable(dev_base_o)));

  // R9: out-of-range device number reads back zero for per-device registers
  p_no_dev_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open_i && dat_rd_i && !ldn_hit && (idx_q == REG_EN || idx_q == REG_BHI)) |->
      (rdata_o == 8'h00));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NDEV   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_alt_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [7:0]         wdata_i,
  output logic [7:0]         rdata_o,
  output logic [NDEV-1:0]    dev_en_o,
  output logic [16*NDEV-1:0] dev_base_o,
  output logic               clk48_sel_o
);
  logic idx_wr, dat_wr, idx_rd, dat_rd;
  logic cfg_open, sel_wr;

  sio_port_dec #(
    .ADDR_W  (ADDR_W),
    .PRI_BASE(ADDR_W'('h4E)),
    .ALT_BASE(ADDR_W'('h2E))
  ) u_dec (
    .strap_alt_i(strap_alt_i),
    .addr_i     (addr_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .idx_wr_o   (idx_wr),
    .dat_wr_o   (dat_wr),
    .idx_rd_o   (idx_rd),
    .dat_rd_o   (dat_rd)
  );

  sio_key_fsm u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_wr_i  (idx_wr),
    .dat_wr_i  (dat_wr),
    .wdata_i   (wdata_i),
    .cfg_open_o(cfg_open),
    .sel_wr_o  (sel_wr)
  );

  sio_reg_bank #(.NDEV(NDEV)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_open_i (cfg_open),
    .sel_wr_i   (sel_wr),
    .dat_wr_i   (dat_wr),
    .idx_rd_i   (idx_rd),
    .dat_rd_i   (dat_rd),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .dev_en_o   (dev_en_o),
    .dev_base_o (dev_base_o),
    .clk48_sel_o(clk48_sel_o)
  );

  // R3: traffic off the selected pair never reaches the key detector
  p_foreign_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !idx_wr && !dat_wr) |=> $stable(cfg_open));
endmodule

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
  localparam int NDEV = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              strap = 1'b0;
  logic [15:0]       addr = '0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic [NDEV-1:0]   dev_en;
  logic [16*NDEV-1:0] dev_base;
  logic              clk48;

  int checks = 0, errors = 0;
  bit done = 0;

  // model
  int          m_st;  // 0 locked, 1 half, 2 open
  logic [7:0]  m_idx, m_ldn, m_gcr;
  logic        m_en [NDEV];
  logic [15:0] m_base [NDEV];

  always #2 clk = ~clk;

  sio_cfg_port #(.ADDR_W(16), .NDEV(NDEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_alt_i(strap), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .dev_en_o(dev_en), .dev_base_o(dev_base), .clk48_sel_o(clk48));

  function automatic logic [15:0] ip();
    return strap ? 16'h002E : 16'h004E;
  endfunction

  task automatic model_reset();
    m_st = 0; m_idx = 0; m_ldn = 0; m_gcr = 0;
    for (int i = 0; i < NDEV; i++) begin m_en[i] = 0; m_base[i] = 0; end
  endtask

  task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
    if (a == ip()) begin
      case (m_st)
        0: m_st = (d == 8'h87) ? 1 : 0;
        1: m_st = (d == 8'h87) ? 2 : 0;
        default: if (d == 8'hAA) m_st = 0; else m_idx = d;
      endcase
    end else if (a == ip() + 16'd1) begin
      if (m_st == 1) m_st = 0;
      else if (m_st == 2) begin
        case (m_idx)
          8'h07: m_ldn = d;
          8'h24: m_gcr = d;
          8'h30: if (m_ldn < NDEV) m_en[m_ldn] = d[0];
          8'h60: if (m_ldn < NDEV) m_base[m_ldn][15:8] = d;
          8'h61: if (m_ldn < NDEV) m_base[m_ldn][7:0] = d;
          default: ;
        endcase
      end
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [15:0] a);
    if (m_st != 2) return 8'hFF;
    if (a == ip()) return m_idx;
    if (a != ip() + 16'd1) return 8'hFF;
    case (m_idx)
      8'h07: return m_ldn;
      8'h24: return m_gcr;
      8'h30: return (m_ldn < NDEV) ? {7'b0, m_en[m_ldn]} : 8'h00;
      8'h60: return (m_ldn < NDEV) ? m_base[m_ldn][15:8] : 8'h00;
      8'h61: return (m_ldn < NDEV) ? m_base[m_ldn][7:0] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    logic [NDEV-1:0] e_en;
    logic [16*NDEV-1:0] e_base;
    for (int i = 0; i < NDEV; i++) begin
      e_en[i] = m_en[i];
      e_base[16*i +: 16] = m_base[i];
    end
    chk({tag, " en"}, 64'(dev_en), 64'(e_en));
    chk({tag, " base"}, 64'(dev_base), 64'(e_base));
    chk({tag, " clk48"}, 64'(clk48), 64'(m_gcr[6]));
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic io_rd(input string tag, input logic [15:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    chk(tag, 64'(rdata), 64'(model_rd(a)));
    @(negedge clk);
    rd = 1'b0;
    #1;
    chk({tag, " idle"}, 64'(rdata), 64'hFF);
  endtask

  task automatic unlock();
    io_wr(ip(), 8'h87);
    io_wr(ip(), 8'h87);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset();

    // R10 reset state
    chk_outs("R10 reset");
    io_rd("R10 locked read", ip() + 16'd1);

    // R1 broken sequence: data write between keys
    io_wr(ip(), 8'h87);
    io_wr(ip() + 16'd1, 8'h11);
    io_wr(ip(), 8'h87);
    io_rd("R1 broken stays locked", ip() + 16'd1);
    io_wr(ip(), 8'h87);
    io_rd("R1 now open idx", ip());
    chk("R1 open", 64'(m_st), 64'd2);

    // R4 index select and readback
    io_wr(ip(), 8'h24);
    io_rd("R4 idx read", ip());
    // R6 clock select
    io_wr(ip() + 16'd1, 8'h40);
    chk_outs("R6 clk48 set");
    chk("R6 clk48", 64'(clk48), 64'd1);
    io_rd("R5 gcr read", ip() + 16'd1);

    // R7 banking
    for (int dv = 0; dv < NDEV; dv++) begin
      io_wr(ip(), 8'h07); io_wr(ip() + 16'd1, 8'(dv));
      io_wr(ip(), 8'h60); io_wr(ip() + 16'd1, 8'(8'hA0 + dv));
      io_wr(ip(), 8'h61); io_wr(ip() + 16'd1, 8'(8'h10 * dv + 3));
      io_wr(ip(), 8'h30); io_wr(ip() + 16'd1, 8'(dv % 2));
    end
    chk_outs("R7 banks");
    io_wr(ip(), 8'h07); io_wr(ip() + 16'd1, 8'd2);
    io_wr(ip(), 8'h60); io_rd("R7 dev2 hi", ip() + 16'd1);
    io_wr(ip(), 8'h30); io_wr(ip() + 16'd1, 8'hFF);
    io_rd("R5 en bit0 only", ip() + 16'd1);

    // R9 undefined register and out-of-range device
    io_wr(ip(), 8'h55); io_wr(ip() + 16'd1, 8'h9C);
    io_rd("R9 undefined reg", ip() + 16'd1);
    io_wr(ip(), 8'h07); io_wr(ip() + 16'd1, 8'd5);
    io_wr(ip(), 8'h61); io_wr(ip() + 16'd1, 8'h77);
    io_rd("R9 ldn out of range", ip() + 16'd1);
    chk_outs("R9 banks unchanged");

    // R2 exit key keeps index
    io_wr(ip(), 8'hAA);
    io_rd("R2 locked after exit", ip() + 16'd1);
    // R8 locked write ignored
    io_wr(ip() + 16'd1, 8'h00);
    chk_outs("R8 locked write");
    unlock();
    io_rd("R2 idx kept", ip());

    // R3 alternate strap
    io_wr(ip(), 8'hAA);
    strap = 1'b1;
    io_wr(16'h004E, 8'h87); io_wr(16'h004E, 8'h87);
    io_rd("R3 old pair dead", 16'h004F);
    unlock();
    io_rd("R3 alt pair open", 16'h002E);
    io_rd("R3 foreign read", 16'h0030);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [7:0] d;
      if (n == 1500) strap = ~strap;
      if (n == 2200) begin do_reset(); chk_outs("R10 mid reset"); end
      r = int'($urandom % 10);
      case (r)
        0, 1: io_wr(ip(), 8'h87);
        2: io_wr(ip(), ($urandom % 3 == 0) ? 8'hAA : 8'($urandom));
        3, 4: begin
          case ($urandom % 6)
            0: d = 8'h07; 1: d = 8'h24; 2: d = 8'h30;
            3: d = 8'h60; 4: d = 8'h61; default: d = 8'($urandom);
          endcase
          io_wr(ip(), d);
        end
        5, 6: begin
          d = (m_idx == 8'h07) ? 8'($urandom % 6) : 8'($urandom);
          io_wr(ip() + 16'd1, d);
        end
        7, 8: io_rd("R5 random read", ip() + 16'd1);
        default: if ($urandom % 2) io_rd("R4 random idx read", ip());
                 else io_wr(16'h0080 + 16'($urandom % 8), 8'h87);
      endcase
      chk_outs("R7 random outs");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule